// File: doc/BRIEF.md
# Byte-Wide Flash Command Front End

This block is a clock-synchronous model of the command interpreter that sits in front of a byte-wide parallel NOR flash array. The host writes commands as an address and data pair qualified by a one-cycle write strobe. It reads by presenting an address with a one-cycle read strobe. The returned byte appears on the next clock. The interpreter watches the write stream for the guarded unlock sequences. Three writes lead into a byte program or into entry and exit of an identification mode. Six writes lead into an erase of one sector or of the whole array.

Once a program or erase job is running, the block is busy for a parameterised number of clock cycles. During that time it answers every read with polling status instead of stored bytes, and it drops every write. The storage is a small register array split into equal sectors. It is scaled down from 4 KB sectors so that the whole array stays a few dozen bytes.

Top module: `pflash_cmd_front`

## Requirements
- R1: After reset, rd_data is 00h, busy is 0, and every array byte reads FFh.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h, followed by a fourth write of (address, data), start a program job. When the job ends, the byte at that address holds its old value ANDed with the data. All other bytes are unchanged.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, followed by a sixth write of data 30h to any address, erase every byte of that address's sector to FFh. Array index bits [ARR_AW-1:SECT_W] select the sector. Other sectors are unchanged.
- R4: The same five-write prefix followed by 5555h/10h erases the whole array to FFh.
- R5: The writes 5555h/AAh, 2AAAh/55h, 5555h/90h enter identification mode. In that mode, a read of address 0 returns BFh and a read of address 1 returns DEV_CODE. Reads of all other addresses return array data.
- R6: Identification mode is left by the three-write prefix ending in 5555h/F0h, or by a single F0h write to any address.
- R7: A write that does not match the step expected next returns the interpreter to its first step and leaves identification mode. Such a write never starts a job.
- R8: While busy is 1, every write is ignored, including an identification exit and complete command sequences.
- R9: busy is 1 for exactly PROG_CYC, SERASE_CYC or CERASE_CYC clock cycles after the edge that accepts the final write of a program, sector erase or chip erase. With the default parameters, CERASE_CYC is greater than SERASE_CYC.
- R10: A read taken while busy returns bits [5:0] as 0. Bit 7 is the complement of bit 7 of the byte being programmed during a program job, and 0 during an erase job.
- R11: Bit 6 of reads taken while busy is 0 for the first read after a job starts and inverts on each further busy read.
- R12: Only the low UNLK_W (15) address bits take part in matching the unlock addresses 5555h and 2AAAh.
- R13: rd_data changes only on the clock edge that samples rd_en high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | BUS_AW (16) | Bus write address |
| wr_data | input | 8 | Bus write data |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | BUS_AW (16) | Read address |
| rd_data | output | 8 | Read result, registered |
| busy | output | 1 | A program or erase job is running |

## Verification
The hardest conditions to reach from the ports are those in which a job is running while other traffic arrives. One is a busy period that overlaps an identification exit or a complete new command sequence. The other is a run of polling reads that must show a clean toggle sequence. The stimulus starts a job and, inside its counted window, pushes whole command sequences and a bare F0h write. Afterwards it reads addresses 0 and 1 to show that the mode flag and the array were left untouched. Reads spaced every other cycle inside an eight-cycle program window give three status samples, so the toggle order and the complemented bit 7 are both checked. A behavioural reference model built from integers and a plain byte array is also compared against rd_data and busy on every clock.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    JOB_NONE   = 2'd0,
    JOB_PROG   = 2'd1,
    JOB_SERASE = 2'd2,
    JOB_CERASE = 2'd3
  } job_e;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U1   = 3'd1,
    SQ_U2   = 3'd2,
    SQ_PGM  = 3'd3,
    SQ_E3   = 3'd4,
    SQ_E4   = 3'd5,
    SQ_E5   = 3'd6
  } seq_e;

  localparam logic [31:0] UNLOCK_A = 32'h0000_5555;
  localparam logic [31:0] UNLOCK_B = 32'h0000_2AAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  OP_PROG  = 8'hA0;
  localparam logic [7:0]  OP_ERASE = 8'h80;
  localparam logic [7:0]  OP_IDON  = 8'h90;
  localparam logic [7:0]  OP_IDOFF = 8'hF0;
  localparam logic [7:0]  OP_SECT  = 8'h30;
  localparam logic [7:0]  OP_CHIP  = 8'h10;
  localparam logic [7:0]  MFR_CODE = 8'hBF;

  // Compare only the low 'w' address bits against a pattern.
  function automatic logic unlock_match(input logic [31:0] addr, input int w,
                                        input logic [31:0] pat);
    logic [31:0] mask;
    mask = (32'h1 << w) - 32'h1;
    return ((addr ^ pat) & mask) == 32'h0;
  endfunction

  // Programming can only clear bits.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b,
                                            input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Byte returned to a read while a job runs.
  function automatic logic [7:0] status_byte(input logic is_prog,
                                             input logic d7,
                                             input logic tog);
    return {(is_prog ? ~d7 : 1'b0), tog, 6'b0};
  endfunction

endpackage

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int BUS_AW = 16,
  parameter int UNLK_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              job_start,
  output job_e              job_kind,
  output logic              seq_abort,
  output logic              id_mode
);

  seq_e state_q, state_d;
  logic id_q, id_d;
  logic hit_a, hit_b, take;

  assign take  = wr_en && !busy;
  assign hit_a = unlock_match(32'(wr_addr), UNLK_W, UNLOCK_A);
  assign hit_b = unlock_match(32'(wr_addr), UNLK_W, UNLOCK_B);

  always_comb begin
    state_d   = state_q;
    id_d      = id_q;
    job_start = 1'b0;
    job_kind  = JOB_NONE;
    seq_abort = 1'b0;
    if (take) begin
      case (state_q)
        SQ_IDLE: if (hit_a && wr_data == KEY_A) state_d = SQ_U1;
                 else seq_abort = 1'b1;
        SQ_U1:   if (hit_b && wr_data == KEY_B) state_d = SQ_U2;
                 else seq_abort = 1'b1;
        SQ_U2: begin
          if (!hit_a) seq_abort = 1'b1;
          else begin
            case (wr_data)
              OP_PROG:  state_d = SQ_PGM;
              OP_ERASE: state_d = SQ_E3;
              OP_IDON:  begin id_d = 1'b1; state_d = SQ_IDLE; end
              OP_IDOFF: begin id_d = 1'b0; state_d = SQ_IDLE; end
              default:  seq_abort = 1'b1;
            endcase
          end
        end
        SQ_PGM: begin
          job_start = 1'b1;
          job_kind  = JOB_PROG;
          state_d   = SQ_IDLE;
        end
        SQ_E3:   if (hit_a && wr_data == KEY_A) state_d = SQ_E4;
                 else seq_abort = 1'b1;
        SQ_E4:   if (hit_b && wr_data == KEY_B) state_d = SQ_E5;
                 else seq_abort = 1'b1;
        SQ_E5: begin
          state_d = SQ_IDLE;
          if (wr_data == OP_SECT) begin
            job_start = 1'b1;
            job_kind  = JOB_SERASE;
          end else if (hit_a && wr_data == OP_CHIP) begin
            job_start = 1'b1;
            job_kind  = JOB_CERASE;
          end else begin
            seq_abort = 1'b1;
          end
        end
        default: seq_abort = 1'b1;
      endcase
      if (seq_abort) begin
        state_d = SQ_IDLE;
        id_d    = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign id_mode = id_q;

endmodule

// File: rtl/pflash_job.sv
module pflash_job
  import pflash_pkg::*;
#(
  parameter int BUS_AW     = 16,
  parameter int PROG_CYC   = 8,
  parameter int SERASE_CYC = 16,
  parameter int CERASE_CYC = 40,
  localparam int MAX_CYC   = (CERASE_CYC > SERASE_CYC) ?
                             ((CERASE_CYC > PROG_CYC) ? CERASE_CYC : PROG_CYC) :
                             ((SERASE_CYC > PROG_CYC) ? SERASE_CYC : PROG_CYC),
  localparam int CNT_W     = $clog2(MAX_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  job_e              kind_in,
  input  logic [BUS_AW-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              busy,
  output logic              done,
  output job_e              kind_q,
  output logic [BUS_AW-1:0] addr_q,
  output logic [7:0]        data_q
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] job_len(input job_e k);
    case (k)
      JOB_PROG:   return CNT_W'(PROG_CYC);
      JOB_SERASE: return CNT_W'(SERASE_CYC);
      JOB_CERASE: return CNT_W'(CERASE_CYC);
      default:    return '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      kind_q <= JOB_NONE;
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      cnt_q  <= job_len(kind_in);
      kind_q <= kind_in;
      addr_q <= addr_in;
      data_q <= data_in;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import pflash_pkg::*;
#(
  parameter int ARR_AW   = 6,
  parameter int SECT_W   = 4,
  localparam int DEPTH   = 1 << ARR_AW,
  localparam int SIDX_W  = ARR_AW - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  job_e              kind,
  input  logic [ARR_AW-1:0] addr,
  input  logic [7:0]        data,
  input  logic [ARR_AW-1:0] rd_idx,
  output logic [7:0]        rd_byte
);

  logic [7:0] mem [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_byte
      localparam logic [ARR_AW-1:0] IDX = ARR_AW'(g);
      logic sect_hit, erase_me, prog_me;
      assign sect_hit = (IDX[ARR_AW-1:SECT_W] == addr[ARR_AW-1:SECT_W]);
      assign erase_me = done && ((kind == JOB_CERASE) ||
                                 (kind == JOB_SERASE && sect_hit));
      assign prog_me  = done && (kind == JOB_PROG) && (addr == IDX);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mem[g] <= 8'hFF;
        else if (erase_me) mem[g] <= 8'hFF;
        else if (prog_me)  mem[g] <= prog_merge(mem[g], data);
      end
    end
  endgenerate

  assign rd_byte = mem[rd_idx];

endmodule

// File: rtl/pflash_cmd_front.sv
module pflash_cmd_front
  import pflash_pkg::*;
#(
  parameter int          BUS_AW     = 16,
  parameter int          ARR_AW     = 6,
  parameter int          SECT_W     = 4,
  parameter int          UNLK_W     = 15,
  parameter int          PROG_CYC   = 8,
  parameter int          SERASE_CYC = 16,
  parameter int          CERASE_CYC = 40,
  parameter logic [7:0]  DEV_CODE   = 8'hD6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy
);

  // Internal events brought out by name for the checker.
  logic              job_start;
  job_e              job_kind;
  logic              seq_abort;
  logic              id_mode;
  logic              job_done;
  job_e              run_kind;
  logic [BUS_AW-1:0] run_addr;
  logic [7:0]        run_data;
  logic [7:0]        arr_byte;
  logic              tog_q;
  logic [7:0]        rd_q;

  pflash_seq #(.BUS_AW(BUS_AW), .UNLK_W(UNLK_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .job_start (job_start),
    .job_kind  (job_kind),
    .seq_abort (seq_abort),
    .id_mode   (id_mode)
  );

  pflash_job #(
    .BUS_AW(BUS_AW), .PROG_CYC(PROG_CYC),
    .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) job_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (job_start),
    .kind_in (job_kind),
    .addr_in (wr_addr),
    .data_in (wr_data),
    .busy    (busy),
    .done    (job_done),
    .kind_q  (run_kind),
    .addr_q  (run_addr),
    .data_q  (run_data)
  );

  pflash_array #(.ARR_AW(ARR_AW), .SECT_W(SECT_W)) arr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (job_done),
    .kind    (run_kind),
    .addr    (run_addr[ARR_AW-1:0]),
    .data    (run_data),
    .rd_idx  (rd_addr[ARR_AW-1:0]),
    .rd_byte (arr_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      if (job_start)
        tog_q <= 1'b0;
      else if (rd_en && busy)
        tog_q <= ~tog_q;
      if (rd_en) begin
        if (busy)
          rd_q <= status_byte(run_kind == JOB_PROG, run_data[7], tog_q);
        else if (id_mode && rd_addr == BUS_AW'(0))
          rd_q <= MFR_CODE;
        else if (id_mode && rd_addr == BUS_AW'(1))
          rd_q <= DEV_CODE;
        else
          rd_q <= arr_byte;
      end
    end
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/pflash_cmd_front_chk.sv
module pflash_cmd_front_chk
  import pflash_pkg::*;
#(
  parameter int PROG_CYC   = 8,
  parameter int SERASE_CYC = 16,
  parameter int CERASE_CYC = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       busy,
  input logic [7:0] rd_data,
  input logic       job_start,
  input job_e       job_kind,
  input job_e       run_kind,
  input logic [7:0] run_data,
  input logic       seq_abort,
  input logic       id_mode
);

  logic [31:0] run_len, exp_len;
  logic        tog_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      exp_len <= '0;
      tog_ref <= 1'b0;
    end else begin
      if (job_start) begin
        run_len <= '0;
        tog_ref <= 1'b0;
        exp_len <= (job_kind == JOB_PROG)   ? 32'(PROG_CYC) :
                   (job_kind == JOB_SERASE) ? 32'(SERASE_CYC) : 32'(CERASE_CYC);
      end else begin
        if (busy) run_len <= run_len + 32'd1;
        if (rd_en && busy) tog_ref <= ~tog_ref;
      end
    end
  end

  p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> busy);

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == exp_len);

  p_ignore_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(id_mode));

  p_abort_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> !id_mode);

  p_erase_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && run_kind != JOB_PROG) |=>
      (rd_data[7] == 1'b0 && rd_data[5:0] == 6'd0));

  p_prog_poll_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && run_kind == JOB_PROG) |=>
      (rd_data[7] != $past(run_data[7]) && rd_data[5:0] == 6'd0));

  p_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> rd_data[6] == $past(tog_ref));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind pflash_cmd_front pflash_cmd_front_chk #(
  .PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .busy      (busy),
  .rd_data   (rd_data),
  .job_start (job_start),
  .job_kind  (job_kind),
  .run_kind  (run_kind),
  .run_data  (run_data),
  .seq_abort (seq_abort),
  .id_mode   (id_mode)
);

// File: tb/pflash_cmd_front_tb_top.sv
module pflash_cmd_front_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PROG_N = 8;
  localparam int SER_N  = 16;
  localparam int CER_N  = 40;
  localparam logic [7:0] DEV = 8'hD6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_cmd_front dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem [64];
  int   m_step;      // 0 idle, 1 AA seen, 2 55 seen, 3 program target, 4..6 erase steps
  bit   m_id;
  int   m_cnt;
  int   m_job;       // 1 program, 2 sector, 3 chip
  int   m_jaddr;
  logic [7:0] m_jdata;
  bit   m_tog;
  logic [7:0] m_rd;
  string m_tag = "R1 reset";

  function automatic bit is5555(input logic [15:0] a);
    return (a & 16'h7FFF) == 16'h5555;
  endfunction
  function automatic bit is2aaa(input logic [15:0] a);
    return (a & 16'h7FFF) == 16'h2AAA;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 8'hFF;
      m_step = 0; m_id = 0; m_cnt = 0; m_job = 0; m_tog = 0; m_rd = 8'h00;
      m_jaddr = 0; m_jdata = 0;
    end else begin
      if (rd_en) begin
        if (m_cnt > 0) begin
          m_rd = 8'h00;
          if (m_job == 1) m_rd[7] = ~m_jdata[7];
          m_rd[6] = m_tog;
          m_tog = !m_tog;
          m_tag = "R10/R11 status";
        end else if (m_id && rd_addr == 16'd0) begin
          m_rd = 8'hBF; m_tag = "R5 id";
        end else if (m_id && rd_addr == 16'd1) begin
          m_rd = DEV; m_tag = "R5 id";
        end else begin
          m_rd = m_mem[rd_addr[5:0]]; m_tag = "R2 array";
        end
      end
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          for (int i = 0; i < 64; i++) begin
            if (m_job == 3 || (m_job == 2 && (i / 16) == (m_jaddr % 64) / 16))
              m_mem[i] = 8'hFF;
          end
          if (m_job == 1) m_mem[m_jaddr % 64] = m_mem[m_jaddr % 64] & m_jdata;
        end
      end else if (wr_en) begin
        bit ok;
        ok = 1'b1;
        if (m_step == 3) begin
          m_job = 1; m_cnt = PROG_N; m_jaddr = int'(wr_addr); m_jdata = wr_data;
          m_tog = 0; m_step = 0;
        end else if (m_step == 0 || m_step == 4)
          if (is5555(wr_addr) && wr_data == 8'hAA) m_step++; else ok = 0;
        else if (m_step == 1 || m_step == 5)
          if (is2aaa(wr_addr) && wr_data == 8'h55) m_step++; else ok = 0;
        else if (m_step == 2) begin
          if (!is5555(wr_addr)) ok = 0;
          else if (wr_data == 8'hA0) m_step = 3;
          else if (wr_data == 8'h80) m_step = 4;
          else if (wr_data == 8'h90) begin m_id = 1; m_step = 0; end
          else if (wr_data == 8'hF0) begin m_id = 0; m_step = 0; end
          else ok = 0;
        end else begin
          m_step = 0;
          if (wr_data == 8'h30) begin
            m_job = 2; m_cnt = SER_N; m_jaddr = int'(wr_addr); m_tog = 0;
          end else if (is5555(wr_addr) && wr_data == 8'h10) begin
            m_job = 3; m_cnt = CER_N; m_tog = 0;
          end else ok = 0;
        end
        if (!ok) begin m_step = 0; m_id = 0; end
      end
    end
  end

  // Compare the model on every clock, away from the edge.
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check(m_tag, rd_data, m_rd);
      check("R9 busy vs model", busy, (m_cnt > 0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, cmd);
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] d);
    unlock3(8'hA0); wr(a, d);
  endtask

  task automatic erase6(input logic [15:0] a, input logic [7:0] d);
    unlock3(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(a, d);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    check("R1 rd_data at reset", rd_data, 8'h00);
    check("R1 busy at reset", busy, 0);
    rst_n = 1;
    rd(16'h0005, v); check("R1 erased after reset", v, 8'hFF);

    // R2 program with polling reads (R10, R11)
    prog(16'h0005, 8'h3C);
    check("R9 busy after program start", busy, 1);
    rd(16'h0005, v); check("R10 R11 first program poll", v, 8'h80);
    rd(16'h0030, v); check("R10 R11 second program poll", v, 8'hC0);
    rd(16'h0005, v); check("R11 third program poll", v, 8'h80);
    wait_idle;
    rd(16'h0005, v); check("R2 programmed byte", v, 8'h3C);
    rd(16'h0006, v); check("R2 neighbour untouched", v, 8'hFF);
    prog(16'h0005, 8'hF0); wait_idle;
    rd(16'h0005, v); check("R2 program ANDs", v, 8'h30);

    // R9 program length
    prog(16'h0006, 8'hFF); busy_len(n); check("R9 program length", n, PROG_N);

    // R13 hold
    repeat (4) @(negedge clk);
    check("R13 rd_data holds", rd_data, 8'h30);

    // R5 / R6 identification
    unlock3(8'h90);
    rd(16'h0000, v); check("R5 manufacturer code", v, 8'hBF);
    rd(16'h0001, v); check("R5 device code", v, DEV);
    rd(16'h0005, v); check("R5 array in id mode", v, 8'h30);
    wr(16'h1234, 8'hF0);
    rd(16'h0000, v); check("R6 single F0 exit", v, 8'hFF);
    unlock3(8'h90);
    rd(16'h0001, v); check("R5 re-entry", v, DEV);
    unlock3(8'hF0);
    rd(16'h0001, v); check("R6 three-write exit", v, 8'hFF);

    // R7 abort
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h00);
    wr(16'h5555, 8'hA0); wr(16'h0009, 8'h00);
    rd(16'h0009, v); check("R7 broken sequence no program", v, 8'hFF);
    check("R7 no job after abort", busy, 0);
    unlock3(8'h90); wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55);
    rd(16'h0000, v); check("R7 abort leaves id mode", v, 8'hFF);

    // R3 sector erase
    prog(16'h0013, 8'h00); wait_idle;
    rd(16'h0013, v); check("R2 program in sector 1", v, 8'h00);
    erase6(16'h0012, 8'h30); busy_len(n);
    check("R9 sector erase length", n, SER_N);
    rd(16'h0013, v); check("R3 sector erased", v, 8'hFF);
    rd(16'h0005, v); check("R3 other sector kept", v, 8'h30);

    // R8 ignore while busy
    prog(16'h0020, 8'h0F);
    unlock3(8'h90);
    rd(16'h0000, v); check("R8 busy status not id", v, 8'h80);
    wait_idle;
    rd(16'h0000, v); check("R8 id entry ignored", v, 8'hFF);
    unlock3(8'h90);
    prog(16'h0021, 8'h11);
    wr(16'h0000, 8'hF0);
    wait_idle;
    rd(16'h0000, v); check("R8 id exit ignored", v, 8'hBF);
    wr(16'h0000, 8'hF0);
    rd(16'h0021, v); check("R2 program in id mode", v, 8'h11);

    // R12 high address bits ignored
    wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'hA0);
    wr(16'h0022, 8'h55); wait_idle;
    rd(16'h0022, v); check("R12 upper bit ignored", v, 8'h55);

    // R4 chip erase with erase polling
    erase6(16'h5555, 8'h10);
    rd(16'h0005, v); check("R10 R11 first erase poll", v, 8'h00);
    rd(16'h0005, v); check("R11 second erase poll", v, 8'h40);
    busy_len(n); check("R9 chip erase remainder", n, CER_N - 4);
    rd(16'h0005, v); check("R4 chip erased sector 0", v, 8'hFF);
    rd(16'h0020, v); check("R4 chip erased sector 2", v, 8'hFF);
    rd(16'h0022, v); check("R4 chip erased byte", v, 8'hFF);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule